// File: doc/BRIEF.md
# Interrupt Aggregator with Message Doorbell

This block gathers 64 interrupt sources into a single summary interrupt line. Sources 0 to 20 come from wired inputs, whose rising edges are caught into sticky pending bits. Sources 21 to 63 are message-signalled: an agent raises one by writing its source number to a doorbell register. Each source also has a mask bit. The summary line is high whenever any source is both pending and unmasked.

Software uses a 32-bit register port. It reads the two pending words and treats them as one 64-bit value, lowest number first. It acknowledges serviced sources by writing ones to the pending word that holds them, and it programs the two mask words. The pending bits and mask bits share the same mapping: source i is bit i mod 32 of word i/32. Reads return data combinationally from the current register state. The summary output is registered.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every pending bit reads 0, every mask bit reads 1 (both mask words read 0xFFFFFFFF), and the summary output is 0.
- R2: The pending words sit at byte offset 0x00 (sources 0–31) and 0x04 (sources 32–63). Source i appears at bit i mod 32 of its word.
- R3: A 0-to-1 transition on wired input k (k = 0..20) sets pending bit k on the next clock edge. An input held high does not set the bit again after it has been cleared.
- R4: Writing a value N with N ≤ 63 to offset 0x30 sets pending bit N, including wired numbers 0–20. Reading offset 0x30 returns zero.
- R5: A write of any value N > 63 to offset 0x30 changes no pending bit.
- R6: Writing to a pending word clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged. A pending bit stays set until it is cleared this way.
- R7: If a set event (a wired rising edge) reaches a pending bit in the same cycle as a clear of that bit, the bit ends up set.
- R8: The mask words sit at offsets 0x20 (sources 0–31) and 0x24 (sources 32–63). A write replaces the whole word, and a read returns it. A mask bit of 1 blocks its source from the summary and 0 passes it.
- R9: The summary output equals, one clock later, the OR over all 64 sources of (pending AND NOT mask).
- R10: Every offset other than 0x00, 0x04, 0x20 and 0x24 reads as zero. A write to any offset other than these four and 0x30 changes no state. This includes unaligned offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe for the current offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| wired_irq | input | 21 | Level inputs for wired sources 0–20 |
| irq_sum | output | 1 | Registered summary interrupt |

## Verification
A wired rising edge can land on a pending bit in the same cycle as a software write that clears that bit. The bench provokes this by raising wired input 7 in the very cycle it writes a one to bit 7 of the low pending word. It judges the outcome by reading that word back and watching the summary line, where the bit must still be present. A random phase later mixes wired edges with pending, mask, doorbell and unmapped writes. Each cycle is compared with a behavioural model that applies clear-then-set ordering.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned PEND_BASE   = 'h00;
  localparam int unsigned MASK_BASE   = 'h20;
  localparam int unsigned BELL_OFS    = 'h30;
  localparam int unsigned WORD_STRIDE = 4;
endpackage

// File: rtl/irqagg_edge_detect.sv
module irqagg_edge_detect #(
  parameter int unsigned WIDTH = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/irqagg_decode.sv
module irqagg_decode
  import irqagg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [NUM_SRC-1:0] clr_o,
  output logic [NUM_SRC-1:0] bell_o,
  output logic [(NUM_SRC+WORD_W-1)/WORD_W-1:0] mask_we_o
);
  localparam int unsigned NWORDS = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_W  = NWORDS * WORD_W;
  localparam int unsigned IDX_W  = $clog2(PAD_W);

  logic [PAD_W-1:0] clr_pad;
  logic [PAD_W-1:0] bell_pad;

  always_comb begin
    clr_pad   = '0;
    bell_pad  = '0;
    mask_we_o = '0;
    for (int k = 0; k < NWORDS; k++) begin
      if (wr_i && addr_i == ADDR_W'(PEND_BASE + k * WORD_STRIDE))
        clr_pad[k*WORD_W +: WORD_W] = wdata_i;
      if (wr_i && addr_i == ADDR_W'(MASK_BASE + k * WORD_STRIDE))
        mask_we_o[k] = 1'b1;
    end
    if (wr_i && addr_i == ADDR_W'(BELL_OFS) && wdata_i < WORD_W'(NUM_SRC))
      bell_pad[wdata_i[IDX_W-1:0]] = 1'b1;
  end

  assign clr_o  = clr_pad[NUM_SRC-1:0];
  assign bell_o = bell_pad[NUM_SRC-1:0];
endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 64,
  parameter int unsigned NUM_WIRED = 21
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WIRED-1:0] rise_i,
  input  logic [NUM_SRC-1:0]   bell_i,
  input  logic [NUM_SRC-1:0]   clr_i,
  input  logic [(NUM_SRC+WORD_W-1)/WORD_W-1:0] mask_we_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [NUM_SRC-1:0]   pend_o,
  output logic [NUM_SRC-1:0]   mask_o,
  output logic                 any_o
);
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] pend_q, pend_n;
  logic [NUM_SRC-1:0] mask_q, mask_n;
  logic               pend_en, mask_en;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i < NUM_WIRED) begin : g_wired
      assign set_vec[i] = bell_i[i] | rise_i[i];
    end else begin : g_msg
      assign set_vec[i] = bell_i[i];
    end
    // set beats clear in the same cycle
    assign pend_n[i] = set_vec[i] | (pend_q[i] & ~clr_i[i]);
    assign mask_n[i] = mask_we_i[i / WORD_W] ? wdata_i[i % WORD_W] : mask_q[i];
  end

  always_comb begin
    pend_en = |(set_vec | clr_i);
    mask_en = |mask_we_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      if (pend_en) pend_q <= pend_n;
      if (mask_en) mask_q <= mask_n;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign any_o  = |(pend_q & ~mask_q);

  p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)))
    else $error("set event lost");

  p_clear_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_vec) != '0) |=> ((pend_q & $past(clr_i & ~set_vec)) == '0))
    else $error("clear ignored");

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0))
    else $error("pending bit dropped without clear");

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_i) != '0) |=> ((pend_q & $past(set_vec & clr_i)) == $past(set_vec & clr_i)))
    else $error("clear beat a set");
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WIRED = 21,
  parameter int unsigned NUM_MSG   = 43
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic [NUM_WIRED-1:0] wired_irq,
  output logic                 irq_sum
);
  localparam int unsigned NUM_SRC = NUM_WIRED + NUM_MSG;
  localparam int unsigned NWORDS  = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_W   = NWORDS * WORD_W;

  logic                 rst_s1, rst_sync_n;
  logic [NUM_WIRED-1:0] rise;
  logic [NUM_SRC-1:0]   clr_vec, bell_vec, pend, mask;
  logic [NWORDS-1:0]    mask_we;
  logic                 any_pend;
  logic [PAD_W-1:0]     pend_pad, mask_pad;
  logic                 irq_q, irq_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  irqagg_edge_detect #(.WIDTH(NUM_WIRED)) u_edge (
    .clk(clk), .rst_n(rst_sync_n), .level_i(wired_irq), .rise_o(rise)
  );

  irqagg_decode #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_dec (
    .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .clr_o(clr_vec), .bell_o(bell_vec), .mask_we_o(mask_we)
  );

  irqagg_bank #(.NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .rise_i(rise), .bell_i(bell_vec),
    .clr_i(clr_vec), .mask_we_i(mask_we), .wdata_i(reg_wdata),
    .pend_o(pend), .mask_o(mask), .any_o(any_pend)
  );

  assign pend_pad = PAD_W'(pend);
  assign mask_pad = PAD_W'(mask);

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NWORDS; k++) begin
      if (reg_addr == ADDR_W'(PEND_BASE + k * WORD_STRIDE))
        reg_rdata = pend_pad[k*WORD_W +: WORD_W];
      if (reg_addr == ADDR_W'(MASK_BASE + k * WORD_STRIDE))
        reg_rdata = mask_pad[k*WORD_W +: WORD_W];
    end
  end

  always_comb irq_n = any_pend;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_n;
  end

  assign irq_sum = irq_q;

  p_summary_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (irq_sum == $past(|(pend & ~mask))))
    else $error("summary does not follow pending and mask");

  p_bell_range_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == ADDR_W'(BELL_OFS) && reg_wdata >= WORD_W'(NUM_SRC) && rise == '0)
    |=> $stable(pend))
    else $error("out-of-range doorbell changed state");

  p_reset_mask_r1: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (mask == '1 && pend == '0))
    else $error("reset state wrong");
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [20:0] wired_irq;
  logic        irq_sum;

  int n_cmp, n_bad;
  logic [63:0] m_pend, m_mask;
  logic [20:0] m_prev;
  logic        m_sum;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wired_irq(wired_irq), .irq_sum(irq_sum)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_pend[31:0];
      8'h04: return m_pend[63:32];
      8'h20: return m_mask[31:0];
      8'h24: return m_mask[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic cycle(input logic [7:0] a, input logic we, input logic [31:0] wd,
                       input logic [20:0] w, input string tag);
    logic [63:0] clr, setv;
    logic [20:0] rise;
    reg_addr = a; reg_wr = we; reg_wdata = wd; wired_irq = w;
    #1;
    n_cmp++;
    if (reg_rdata !== m_read(a)) begin
      n_bad++;
      $display("FAIL %s: read @%h got %h exp %h", tag, a, reg_rdata, m_read(a));
    end
    // model next state: clear first, then set
    rise = w & ~m_prev;
    clr = 64'h0; setv = {43'h0, rise};
    if (we && a == 8'h00) clr[31:0]  = wd;
    if (we && a == 8'h04) clr[63:32] = wd;
    if (we && a == 8'h30 && wd < 64) setv[wd[5:0]] = 1'b1;
    m_sum = |(m_pend & ~m_mask);
    m_pend = (m_pend & ~clr) | setv;
    if (we && a == 8'h20) m_mask[31:0]  = wd;
    if (we && a == 8'h24) m_mask[63:32] = wd;
    m_prev = w;
    @(posedge clk); @(negedge clk);
    n_cmp++;
    if (irq_sum !== m_sum) begin
      n_bad++;
      $display("FAIL R9 (%s): irq_sum got %b exp %b", tag, irq_sum, m_sum);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cycle(a, 1'b0, 32'h0, m_prev, tag);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    m_pend = '0; m_mask = '1; m_prev = '0; m_sum = 1'b0;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; wired_irq = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h20, "R1"); rd(8'h24, "R1");
    // R10 unmapped reads, R4 doorbell reads zero
    rd(8'h10, "R10"); rd(8'h30, "R4"); rd(8'h01, "R10");
    // R8 unmask everything
    cycle(8'h20, 1'b1, 32'h0, '0, "R8");
    cycle(8'h24, 1'b1, 32'h0, '0, "R8");
    rd(8'h20, "R8"); rd(8'h24, "R8");
    // R3 wired edges on 0 and 20
    cycle(8'h00, 1'b0, 0, 21'h100001, "R3");
    cycle(8'h00, 1'b0, 0, 21'h0, "R3");
    rd(8'h00, "R2");
    // R6 clear bit 0 only
    cycle(8'h00, 1'b1, 32'h1, '0, "R6");
    rd(8'h00, "R6");
    cycle(8'h00, 1'b1, 32'h0010_0000, '0, "R6");
    rd(8'h00, "R6");
    // R3 held level: rise once, clear, stays clear
    cycle(8'h00, 1'b0, 0, 21'h20, "R3");
    cycle(8'h00, 1'b0, 0, 21'h20, "R3");
    cycle(8'h00, 1'b1, 32'h20, 21'h20, "R3");
    rd(8'h00, "R3"); rd(8'h00, "R3");
    cycle(8'h00, 1'b0, 0, 21'h0, "R3");
    // R4 doorbell numbers
    cycle(8'h30, 1'b1, 21, '0, "R4");
    cycle(8'h30, 1'b1, 31, '0, "R4");
    cycle(8'h30, 1'b1, 32, '0, "R4");
    cycle(8'h30, 1'b1, 63, '0, "R4");
    cycle(8'h30, 1'b1, 5, '0, "R4");
    rd(8'h00, "R2"); rd(8'h04, "R2");
    // R5 out of range
    cycle(8'h30, 1'b1, 64, '0, "R5");
    cycle(8'h30, 1'b1, 32'hFFFF_FFFF, '0, "R5");
    cycle(8'h30, 1'b1, 32'h0000_0100, '0, "R5");
    rd(8'h00, "R5"); rd(8'h04, "R5");
    // R6 mixed clear of upper word
    cycle(8'h04, 1'b1, 32'h0000_0001, '0, "R6");
    rd(8'h04, "R6");
    // R7 rise on 7 with clear of 7 in the same cycle
    cycle(8'h00, 1'b1, 32'h0000_0080, 21'h80, "R7");
    rd(8'h00, "R7");
    cycle(8'h00, 1'b1, 32'hFFFF_FFFF, 21'h0, "R6");
    rd(8'h00, "R6");
    // R8 masking: only bit 63 pending, mask it then unmask
    cycle(8'h24, 1'b1, 32'h8000_0000, '0, "R8");
    rd(8'h24, "R8"); rd(8'h04, "R8");
    cycle(8'h24, 1'b1, 32'h0, '0, "R8");
    rd(8'h04, "R9");
    // R10 writes to unmapped offsets
    cycle(8'h40, 1'b1, 32'hFFFF_FFFF, '0, "R10");
    cycle(8'h21, 1'b1, 32'hFFFF_FFFF, '0, "R10");
    cycle(8'h31, 1'b1, 32'd3, '0, "R10");
    rd(8'h00, "R10"); rd(8'h04, "R10"); rd(8'h20, "R10"); rd(8'h24, "R10");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [20:0] w;
      case ($urandom % 8)
        0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h20; 3: a = 8'h24;
        4, 5: a = 8'h30; 6: a = 8'h10; default: a = 8'h02;
      endcase
      d = (a == 8'h30) ? ($urandom % 80) : $urandom;
      w = (($urandom % 3) == 0) ? 21'($urandom) : m_prev;
      cycle(a, 1'($urandom % 2), d, w, "R7");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule